// File: doc/BRIEF.md
# Round-Robin Serial ADC Sequencer

A receive-only serial master that polls a set of external converters, one channel at a time, in fixed rotation. For each channel it pulls the frame strobe `cs_n_o` low, drives the channel number on `sel_o`, and toggles a divided serial clock sixteen times. It captures the shared data line `sdi_i` on every rising clock edge and then releases the strobe. The captured frame is cut down to the sample width of the selected format, right-aligned, and written into that channel's result register. A host reads any result register at any time through a combinational read port.

Three conversion formats are selected by `mode_i`. Format A uses one four-input converter whose two select inputs take `sel_o[1:0]` directly; it has 12-bit samples and at most 4 channels. Formats B and C have one converter per channel. An external 3-to-8 decoder turns `sel_o` into per-converter active-low selects. Format B has 15-bit samples and format C has 16-bit samples, each with up to 8 channels. `en_i` starts and stops the rotation. `chan_cnt_i` sets how many channels take part. Format and channel count are sampled only when a round begins.

Top module: `rr_adc_seq`

## Requirements
- R1: While reset is held and after its release, `cs_n_o` is 1, `sclk_o` is 0, `sel_o` is 0 and every result register reads 0.
- R2: While `en_i` is 0 and the block is idle, no frame starts. If `en_i` falls during a frame, that frame completes and writes its result, and then no further frame starts.
- R3: Channels are visited in the order 0, 1, ..., N-1 and then wrap to 0. `sel_o` carries the binary channel number during each frame.
- R4: The active count N is `chan_cnt_i`, with 0 treated as 1. Values above the limit are cut to 4 in format A and to 8 in formats B and C.
- R5: Format A (`mode_i` = 2'b00) stores the last 12 bits of the 16-bit frame in bits 11:0 of the result. Bits 15:12 read 0.
- R6: Format B (`mode_i` = 2'b01) stores the last 15 bits of the frame in bits 14:0. Bit 15 reads 0.
- R7: Format C (`mode_i` = 2'b10, and 2'b11 behaves the same) stores all 16 frame bits.
- R8: Each frame has exactly 16 rising edges of `sclk_o` while `cs_n_o` is low. `sdi_i` is sampled on each rising edge, most significant bit first. `sclk_o` is low whenever `cs_n_o` is high.
- R9: Between two frames, `cs_n_o` stays high for at least GAP_CYC (default 2) system clocks.
- R10: A change of `mode_i` or `chan_cnt_i` takes effect only when the rotation wraps to channel 0, or when it starts from idle.
- R11: `sel_o` is stable for the whole of a frame. In format A, `sel_o[2]` is 0.
- R12: `rd_data_o` returns the result register selected by `rd_addr_i`. A frame changes only the register of its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the rotation |
| mode_i | input | 2 | Conversion format: 00 A, 01 B, 10/11 C |
| chan_cnt_i | input | 4 | Number of active channels |
| sdi_i | input | 1 | Shared serial data from the converters |
| rd_addr_i | input | 3 | Result register index |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Frame strobe, active low |
| sel_o | output | 3 | Binary channel number |
| rd_data_o | output | 16 | Selected result, right-aligned |

## Verification
Two events can land in the same system clock: the write of the last frame of a round, and the latch of a new format and channel count at the wrap. The same holds for a frame's result write and the decision to stop after `en_i` falls. The bench changes `mode_i` and `chan_cnt_i`, and drops `en_i`, in the middle of a frame. It keeps its own model of channel order and masking, latched only when its expected channel returns to 0. Every frame's channel number and stored value are checked against that model. After each write, a neighbouring register is read to confirm it did not change.

// File: rtl/rr_adc_pkg.sv
package rr_adc_pkg;
  localparam int N_CH       = 8;
  localparam int CH_W       = $clog2(N_CH);
  localparam int CNT_W      = CH_W + 1;
  localparam int FRAME_BITS = 16;
  localparam int BIT_W      = $clog2(FRAME_BITS + 1);
  localparam int W_A        = 12;
  localparam int W_B        = 15;
  localparam int W_C        = 16;

  typedef enum logic [1:0] {
    MODE_A  = 2'b00,
    MODE_B  = 2'b01,
    MODE_C  = 2'b10,
    MODE_C2 = 2'b11
  } mode_e;

  function automatic logic [CNT_W-1:0] max_ch(mode_e m);
    return (m == MODE_A) ? CNT_W'(N_CH / 2) : CNT_W'(N_CH);
  endfunction

  function automatic logic [CH_W-1:0] last_idx(mode_e m, logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] k;
    lim = max_ch(m);
    if (n == '0)     k = CNT_W'(1);
    else if (n > lim) k = lim;
    else             k = n;
    return CH_W'(k - 1'b1);
  endfunction

  function automatic logic [FRAME_BITS-1:0] samp_mask(mode_e m);
    int w;
    case (m)
      MODE_A:  w = W_A;
      MODE_B:  w = W_B;
      default: w = W_C;
    endcase
    return FRAME_BITS'((33'd1 << w) - 33'd1);
  endfunction
endpackage

// File: rtl/rr_adc_clkdiv.sv
module rr_adc_clkdiv #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rr_adc_ctl.sv
module rr_adc_ctl
  import rr_adc_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  mode_e            mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic             rise_o,
  output logic             done_o,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic [CH_W-1:0]  chan_o,
  output logic [CH_W-1:0]  last_o,
  output mode_e            mode_o
);
  localparam int GW = $clog2(GAP_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CLK, ST_GAP} st_e;

  st_e              st_q;
  logic             sclk_q;
  logic [BIT_W-1:0] bit_q;
  logic [GW-1:0]    gap_q;
  logic [CH_W-1:0]  chan_q, last_q;
  mode_e            mode_q;

  assign run_o  = (st_q == ST_CLK);
  assign rise_o = run_o && tick_i && !sclk_q;
  assign done_o = run_o && tick_i && sclk_q && (bit_q == BIT_W'(FRAME_BITS));
  assign sclk_o = sclk_q;
  assign cs_n_o = !run_o;
  assign chan_o = chan_q;
  assign last_o = last_q;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      gap_q  <= '0;
      chan_q <= '0;
      last_q <= '0;
      mode_q <= MODE_A;
    end else begin
      case (st_q)
        ST_IDLE: if (en_i) begin
          st_q   <= ST_CLK;
          chan_q <= '0;
          mode_q <= mode_i;
          last_q <= last_idx(mode_i, cnt_i);
          bit_q  <= '0;
          sclk_q <= 1'b0;
        end
        ST_CLK: if (tick_i) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            bit_q  <= bit_q + 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == BIT_W'(FRAME_BITS)) begin
              st_q  <= ST_GAP;
              gap_q <= '0;
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GW'(GAP_CYC - 1)) begin
            bit_q <= '0;
            if (!en_i) begin
              st_q   <= ST_IDLE;
              chan_q <= '0;
            end else begin
              st_q <= ST_CLK;
              if (chan_q == last_q) begin
                // round boundary: new format and count apply here
                chan_q <= '0;
                mode_q <= mode_i;
                last_q <= last_idx(mode_i, cnt_i);
              end else begin
                chan_q <= chan_q + 1'b1;
              end
            end
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rr_adc_shift.sv
module rr_adc_shift
  import rr_adc_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rise_i,
  input  logic                  sdi_i,
  input  mode_e                 mode_i,
  output logic [FRAME_BITS-1:0] data_o
);
  logic [FRAME_BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (rise_i) sh_q <= {sh_q[FRAME_BITS-2:0], sdi_i};
  end

  // leading frame bits beyond the sample width are dropped
  assign data_o = sh_q & samp_mask(mode_i);
endmodule

// File: rtl/rr_adc_bank.sv
module rr_adc_bank #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (we_i && (waddr_i == AW'(g)))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rr_adc_seq.sv
module rr_adc_seq
  import rr_adc_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int GAP_CYC  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [1:0]            mode_i,
  input  logic [CNT_W-1:0]      chan_cnt_i,
  input  logic                  sdi_i,
  input  logic [CH_W-1:0]       rd_addr_i,
  output logic                  sclk_o,
  output logic                  cs_n_o,
  output logic [CH_W-1:0]       sel_o,
  output logic [FRAME_BITS-1:0] rd_data_o
);
  logic                  run, tick, rise, done;
  logic [CH_W-1:0]       chan, last_lat;
  mode_e                 mode_lat;
  logic [FRAME_BITS-1:0] samp;

  rr_adc_clkdiv #(.DIV(DIV_HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  rr_adc_ctl #(.GAP_CYC(GAP_CYC)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_e'(mode_i)),
    .cnt_i  (chan_cnt_i),
    .tick_i (tick),
    .run_o  (run),
    .rise_o (rise),
    .done_o (done),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .chan_o (chan),
    .last_o (last_lat),
    .mode_o (mode_lat)
  );

  rr_adc_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .sdi_i  (sdi_i),
    .mode_i (mode_lat),
    .data_o (samp)
  );

  rr_adc_bank #(.N(N_CH), .DW(FRAME_BITS), .AW(CH_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done),
    .waddr_i (chan),
    .wdata_i (samp),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  // format A: top select line unused, two lines go straight to the converter
  assign sel_o = (mode_lat == MODE_A) ? {1'b0, chan[CH_W-2:0]} : chan;
endmodule

// File: rtl/rr_adc_seq_chk.sv
module rr_adc_seq_chk #(
  parameter int GAP_CYC = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sclk_o,
  input logic       cs_n_o,
  input logic [2:0] sel_o,
  input logic [1:0] mode_i,
  input logic [2:0] last_i
);
  logic [7:0] hi_cnt_q;
  logic [4:0] rises_q;
  logic       sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      rises_q  <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_n_o) hi_cnt_q <= (hi_cnt_q == 8'hff) ? hi_cnt_q : hi_cnt_q + 1'b1;
      else        hi_cnt_q <= '0;
      if (cs_n_o)                  rises_q <= '0;
      else if (sclk_o && !sclk_d)  rises_q <= rises_q + 1'b1;
    end
  end

  p_sclk_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  p_sixteen_rises_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> rises_q == 5'd16);

  p_gap_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && hi_cnt_q != 8'd0) |-> hi_cnt_q >= 8'(GAP_CYC));

  p_sel_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && $past(!cs_n_o)) |-> $stable(sel_o));

  p_mode_a_top_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && mode_i == 2'b00) |-> !sel_o[2]);

  p_sel_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> sel_o <= last_i);
endmodule

bind rr_adc_seq rr_adc_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sclk_o (sclk_o),
  .cs_n_o (cs_n_o),
  .sel_o  (sel_o),
  .mode_i (mode_lat),
  .last_i (last_lat)
);

// File: tb/rr_adc_seq_tb_top.sv
`timescale 1ns/1ps
module rr_adc_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  mode_i = 2'b10;
  logic [3:0]  chan_cnt_i = 4'd3;
  logic        sdi_i = 1'b0;
  logic [2:0]  rd_addr_i = 3'd0;
  logic        sclk_o, cs_n_o;
  logic [2:0]  sel_o;
  logic [15:0] rd_data_o;

  always #2 clk_i = ~clk_i;

  rr_adc_seq dut_i (.*);

  typedef struct {
    logic [2:0]  ch;
    logic [15:0] val;
    logic [1:0]  md;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  int exp_ch = 0, m_last = 0, frame_idx = 0, hi_cnt = 0, rises = 0;
  logic [1:0] m_mode = 2'b00;
  bit restart = 1'b1;
  logic [15:0] shadow [8];
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int f_last(logic [1:0] m, int c);
    int lim = (m == 2'b00) ? 4 : 8;
    int n = (c == 0) ? 1 : ((c > lim) ? lim : c);
    return n - 1;
  endfunction

  function automatic logic [15:0] f_mask(logic [1:0] m);
    return (m == 2'b00) ? 16'h0fff : ((m == 2'b01) ? 16'h7fff : 16'hffff);
  endfunction

  always @(negedge clk_i) begin
    if (cs_n_o === 1'b1) hi_cnt++;
    else                 hi_cnt = 0;
  end

  always @(posedge sclk_o) if (cs_n_o === 1'b0) rises++;

  // driver: converter model, pushes expected results
  initial begin
    @(posedge rst_ni);
    forever begin
      logic [15:0] word;
      exp_t e;
      @(negedge cs_n_o);
      chk(hi_cnt >= 2, "R9 gap", hi_cnt, 2);
      #1;
      if (restart) begin
        exp_ch = 0;
        restart = 1'b0;
      end else begin
        exp_ch = (exp_ch == m_last) ? 0 : exp_ch + 1;
      end
      if (exp_ch == 0) begin
        m_mode = mode_i;
        m_last = f_last(mode_i, int'(chan_cnt_i));
      end
      chk(sel_o == 3'(exp_ch), "R3/R4/R10/R11 channel", sel_o, exp_ch);
      word = 16'hb5c3 ^ 16'(frame_idx * 16'h1357) ^ 16'(frame_idx << 13);
      frame_idx++;
      e.ch = 3'(exp_ch);
      e.md = m_mode;
      e.val = word & f_mask(m_mode);
      q.push_back(e);
      sdi_i = word[15];
      for (int i = 14; i >= 0; i--) begin
        @(negedge sclk_o);
        sdi_i = word[i];
      end
    end
  end

  // monitor: owns the read port
  initial begin
    #3;
    chk(cs_n_o == 1'b1 && sclk_o == 1'b0 && sel_o == 3'd0, "R1 outputs in reset",
        {cs_n_o, sclk_o, sel_o}, 5'b10000);
    for (int a = 0; a < 8; a++) begin
      rd_addr_i = 3'(a);
      #1;
      chk(rd_data_o == 16'h0, "R1 result reset", rd_data_o, 0);
      shadow[a] = 16'h0;
    end
    @(posedge rst_ni);
    forever begin
      exp_t e;
      string tag;
      @(posedge cs_n_o);
      chk(rises == 16, "R8 rising edges", rises, 16);
      rises = 0;
      #1;
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected frame", 0, 1);
      end else begin
        e = q.pop_front();
        rd_addr_i = e.ch;
        #1;
        tag = (e.md == 2'b00) ? "R5 format A" : ((e.md == 2'b01) ? "R6 format B" : "R7 format C");
        chk(rd_data_o == e.val, tag, rd_data_o, e.val);
        shadow[e.ch] = e.val;
        rd_addr_i = e.ch + 3'd1;
        #1;
        chk(rd_data_o == shadow[e.ch + 3'd1], "R12 other channel kept",
            rd_data_o, shadow[e.ch + 3'd1]);
      end
    end
  end

  task automatic frames(input int n);
    repeat (n) @(posedge cs_n_o);
  endtask

  task automatic quiet(input int n, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (cs_n_o !== 1'b1 || sclk_o !== 1'b0) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  // stimulus
  initial begin
    repeat (5) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    quiet(100, "R2 idle while disabled");

    // format C, 3 channels
    en_i = 1'b1;
    frames(9);

    // switch to format A with an oversized count mid-round
    @(negedge cs_n_o);
    repeat (10) @(posedge clk_i);
    mode_i = 2'b00;
    chan_cnt_i = 4'd6;
    frames(12);

    // format B with count 0, then code 3 with count 9
    @(negedge cs_n_o);
    repeat (10) @(posedge clk_i);
    mode_i = 2'b01;
    chan_cnt_i = 4'd0;
    frames(6);
    @(negedge cs_n_o);
    repeat (10) @(posedge clk_i);
    mode_i = 2'b11;
    chan_cnt_i = 4'd9;
    frames(18);

    // stop in the middle of a frame
    @(negedge cs_n_o);
    repeat (5) @(posedge clk_i);
    en_i = 1'b0;
    @(posedge cs_n_o);
    repeat (4) @(posedge clk_i);
    chk(q.size() == 0, "R2 last frame written", q.size(), 0);
    quiet(300, "R2 no frame after stop");
    restart = 1'b1;

    // restart in format B, 8 channels
    mode_i = 2'b01;
    chan_cnt_i = 4'd8;
    @(negedge clk_i);
    en_i = 1'b1;
    frames(10);
    @(negedge cs_n_o);
    en_i = 1'b0;
    @(posedge cs_n_o);
    repeat (10) @(posedge clk_i);
    chk(q.size() == 0, "R2 queue drained", q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule